// File: doc/BRIEF.md
# Electronic Shutter Pulse Generator

This block drives the substrate-clear pulses that empty a CCD's photosites early in each field, which sets the exposure time electronically. It also drives a mechanical-shutter command and a flash strobe command. A horizontal/vertical counter supplies the pixel position inside the line and the line number inside the field. A configuration bank supplies the settings as plain static inputs, together with the line that carries the sensor-gate pulse.

Normal clearing pulses come one per line. They start at line 0 and stop at the programmed count or at the sensor-gate line, whichever comes first. The exposure therefore runs from the last clearing line to the gate line, and the strobe covers that span. On the gate line, a high-precision section can place a single fine pulse or a burst of fine pulses ahead of the gate window. Several controls act on the pulses: a one-shot suppression, masking by the mechanical shutter, and output enables. Every output is registered, so it reflects the counter and configuration values of the previous clock.

Top module: `eshutter_gen`

## Requirements
- R1: While `rst` is high at a clock edge, all four outputs are low after that edge, and the one-shot suppression flag is cleared.
- R2: Every output equals its function of the inputs sampled at the previous rising edge. For pattern A (`cfg_pat_sel`=0), `subck_o` is high on each line v < min(count, `vsg_line`) while `h_pos` is in the range 2..4.
- R3: For pattern B (`cfg_pat_sel`=1), normal pulses occupy `h_pos` 10..15 on the same lines.
- R4: The count is 11 bits wide. A count of 0 gives no normal pulse. A count of 0x7FF (the register's power-on value) lets the sensor-gate line alone bound the pulses.
- R5: The suppression flag is armed at the last gate cycle (`h_pos`=43 on the gate line, with the gate enabled). The next normal-line window consumes the flag at `h_pos` 4 (pattern A) or 15 (pattern B), even when the pulse is blocked by the enable or the mask. When `cfg_skip_first`=1, the pulse in that window is removed. High-precision pulses are never suppressed.
- R6: Single high-precision mode (`cfg_hp_multi`=0) gives one 1-clock pulse on the gate line at `h_pos` = 20 + 2·`cfg_hp_num`.
- R7: Multiple high-precision mode gives `cfg_hp_num` 1-clock pulses on the gate line at `h_pos` = 20 + 2k, for k = 0 .. `cfg_hp_num`−1. A value of 0 gives no pulse.
- R8: With `cfg_mshut_mask`=1, `subck_o` is low whenever the mechanical-shutter command is active. With `cfg_mshut_mask`=0, the command has no effect on `subck_o`.
- R9: With `cfg_shut_en`=0, `subck_o` stays low.
- R10: `vsg_o` is high on the gate line for `h_pos` 40..43 when `cfg_gate_en`=1, and stays low otherwise.
- R11: `cfg_mshut_pat` selects the shutter command: 0 always low, 1 high on lines ≥ `vsg_line`, 2 high on lines < `vsg_line`, 3 always high.
- R12: `strobe_o` is high on lines from min(count, `vsg_line`) up to `vsg_line`−1 when `cfg_strobe_en`=1, and stays low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| h_pos | input | 12 | Pixel position within the line |
| v_line | input | 11 | Line number within the field |
| vsg_line | input | 11 | Line carrying the sensor-gate pulse |
| cfg_shut_count | input | 11 | Normal clearing pulses per field |
| cfg_pat_sel | input | 1 | Normal pulse pattern: 0 = A, 1 = B |
| cfg_skip_first | input | 1 | Remove the first normal pulse after a gate |
| cfg_hp_multi | input | 1 | High-precision mode: 0 single, 1 multiple |
| cfg_hp_num | input | 3 | High-precision position (single) or count (multiple) |
| cfg_mshut_mask | input | 1 | Let an active shutter command block clearing pulses |
| cfg_shut_en | input | 1 | Clearing pulse output enable |
| cfg_gate_en | input | 1 | Sensor-gate output enable |
| cfg_mshut_pat | input | 2 | Mechanical-shutter pattern select |
| cfg_strobe_en | input | 1 | Strobe output enable |
| subck_o | output | 1 | Substrate clearing pulse |
| vsg_o | output | 1 | Sensor-gate pulse |
| mshut_o | output | 1 | Mechanical-shutter command |
| strobe_o | output | 1 | Flash strobe command |

## Verification
The bench sweeps 48 fields. Each field uses a different mix of count, gate line, pattern, modes and enables, and every cycle is compared against an arithmetic model. The sweep includes gate line 0, a count of 0, and a count larger than the gate line, so a design that took the wrong bound would pulse past the gate or miss the strobe span. Suppression is checked across field boundaries, including fields whose count is 0 or whose enable is off. A flag that was not consumed by a blocked pulse would wrongly swallow a pulse in a later field. An off-by-one in the high-precision slot count would show up as an extra or missing fine pulse when `cfg_hp_num` is 0 or 7.

// File: rtl/eshutter_pkg.sv
package eshutter_pkg;

    typedef enum logic [1:0] {
        MS_OPEN         = 2'd0,
        MS_CLOSE_EXPOSE = 2'd1,
        MS_CLOSE_EARLY  = 2'd2,
        MS_CLOSED       = 2'd3
    } mshut_pat_e;

    typedef struct packed {
        logic norm_hit;
        logic norm_end;
        logic hp_hit;
        logic gate_hit;
        logic gate_end;
    } line_evt_t;

    function automatic logic in_win(input int h, input int pos, input int wid);
        return (h >= pos) && (h < pos + wid);
    endfunction

    function automatic logic at_last(input int h, input int pos, input int wid);
        return h == (pos + wid - 1);
    endfunction

endpackage

// File: rtl/shut_line_sched.sv
module shut_line_sched
    import eshutter_pkg::*;
#(
    parameter int HW        = 12,
    parameter int VW        = 11,
    parameter int CW        = 11,
    parameter int POS_A     = 2,
    parameter int WID_A     = 3,
    parameter int POS_B     = 10,
    parameter int WID_B     = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [HW-1:0] h_pos,
    input  logic [VW-1:0] v_line,
    input  logic [VW-1:0] vsg_line,
    input  logic [CW-1:0] count,
    input  logic          pat_sel,
    output logic [VW-1:0] stop_line,
    output logic          norm_hit,
    output logic          norm_end
);
    logic norm_line;
    logic win_a, win_b, end_a, end_b;

    always_comb begin
        stop_line = (int'(count) < int'(vsg_line)) ? VW'(count) : vsg_line;
        norm_line = int'(v_line) < int'(stop_line);
        win_a     = in_win(int'(h_pos), POS_A, WID_A);
        win_b     = in_win(int'(h_pos), POS_B, WID_B);
        end_a     = at_last(int'(h_pos), POS_A, WID_A);
        end_b     = at_last(int'(h_pos), POS_B, WID_B);
        norm_hit  = norm_line && (pat_sel ? win_b : win_a);
        norm_end  = norm_line && (pat_sel ? end_b : end_a);
    end

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        norm_hit |-> (int'(v_line) < int'(count)) && (v_line < vsg_line)); // R4

endmodule

// File: rtl/shut_hp_gen.sv
module shut_hp_gen
    import eshutter_pkg::*;
#(
    parameter int HW      = 12,
    parameter int NUM_W   = 3,
    parameter int HP_BASE = 20,
    parameter int HP_STEP = 2,
    parameter int HP_WID  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [HW-1:0]    h_pos,
    input  logic             multi,
    input  logic [NUM_W-1:0] num,
    output logic             hp_hit
);
    localparam int SLOTS = 1 << NUM_W;

    logic [SLOTS-1:0] slot_hit;
    logic [SLOTS-1:0] slot_on;

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign slot_hit[k] = in_win(int'(h_pos), HP_BASE + k * HP_STEP, HP_WID);
        assign slot_on[k]  = multi ? (k < int'(num)) : (k == int'(num));
    end

    assign hp_hit = |(slot_hit & slot_on);

    AST_HP_SLOTS_DISJOINT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(slot_hit)); // R7

endmodule

// File: rtl/shut_aux_gen.sv
module shut_aux_gen
    import eshutter_pkg::*;
#(
    parameter int VW = 11
) (
    input  logic [VW-1:0] v_line,
    input  logic [VW-1:0] vsg_line,
    input  logic [VW-1:0] stop_line,
    input  logic [1:0]    mshut_pat,
    input  logic          strobe_en,
    output logic          mshut_c,
    output logic          strobe_c
);
    mshut_pat_e pat;

    always_comb begin
        pat = mshut_pat_e'(mshut_pat);
        unique case (pat)
            MS_OPEN:         mshut_c = 1'b0;
            MS_CLOSE_EXPOSE: mshut_c = v_line >= vsg_line;
            MS_CLOSE_EARLY:  mshut_c = v_line < vsg_line;
            default:         mshut_c = 1'b1;
        endcase
        strobe_c = strobe_en && (v_line >= stop_line) && (v_line < vsg_line);
    end

endmodule

// File: rtl/eshutter_gen.sv
module eshutter_gen
    import eshutter_pkg::*;
#(
    parameter int HW      = 12,
    parameter int VW      = 11,
    parameter int CW      = 11,
    parameter int HPN_W   = 3,
    parameter int POS_A   = 2,
    parameter int WID_A   = 3,
    parameter int POS_B   = 10,
    parameter int WID_B   = 6,
    parameter int HP_BASE = 20,
    parameter int HP_STEP = 2,
    parameter int HP_WID  = 1,
    parameter int GATE_POS = 40,
    parameter int GATE_WID = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [HW-1:0]    h_pos,
    input  logic [VW-1:0]    v_line,
    input  logic [VW-1:0]    vsg_line,
    input  logic [CW-1:0]    cfg_shut_count,
    input  logic             cfg_pat_sel,
    input  logic             cfg_skip_first,
    input  logic             cfg_hp_multi,
    input  logic [HPN_W-1:0] cfg_hp_num,
    input  logic             cfg_mshut_mask,
    input  logic             cfg_shut_en,
    input  logic             cfg_gate_en,
    input  logic [1:0]       cfg_mshut_pat,
    input  logic             cfg_strobe_en,
    output logic             subck_o,
    output logic             vsg_o,
    output logic             mshut_o,
    output logic             strobe_o
);
    line_evt_t     evt;
    logic [VW-1:0] stop_line;
    logic          mshut_c, strobe_c;
    logic          gate_line;
    logic          skip_armed;
    logic          subck_c;

    shut_line_sched #(
        .HW(HW), .VW(VW), .CW(CW),
        .POS_A(POS_A), .WID_A(WID_A), .POS_B(POS_B), .WID_B(WID_B)
    ) u_sched (
        .clk      (clk),
        .rst      (rst),
        .h_pos    (h_pos),
        .v_line   (v_line),
        .vsg_line (vsg_line),
        .count    (cfg_shut_count),
        .pat_sel  (cfg_pat_sel),
        .stop_line(stop_line),
        .norm_hit (evt.norm_hit),
        .norm_end (evt.norm_end)
    );

    shut_hp_gen #(
        .HW(HW), .NUM_W(HPN_W),
        .HP_BASE(HP_BASE), .HP_STEP(HP_STEP), .HP_WID(HP_WID)
    ) u_hp (
        .clk   (clk),
        .rst   (rst),
        .h_pos (h_pos),
        .multi (cfg_hp_multi),
        .num   (cfg_hp_num),
        .hp_hit(evt.hp_hit)
    );

    shut_aux_gen #(.VW(VW)) u_aux (
        .v_line   (v_line),
        .vsg_line (vsg_line),
        .stop_line(stop_line),
        .mshut_pat(cfg_mshut_pat),
        .strobe_en(cfg_strobe_en),
        .mshut_c  (mshut_c),
        .strobe_c (strobe_c)
    );

    always_comb begin
        gate_line    = v_line == vsg_line;
        evt.gate_hit = gate_line && in_win(int'(h_pos), GATE_POS, GATE_WID);
        evt.gate_end = gate_line && at_last(int'(h_pos), GATE_POS, GATE_WID);
        subck_c = cfg_shut_en && !(cfg_mshut_mask && mshut_c) &&
                  ((evt.norm_hit && !(skip_armed && cfg_skip_first)) ||
                   (gate_line && evt.hp_hit));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            skip_armed <= 1'b0;
            subck_o    <= 1'b0;
            vsg_o      <= 1'b0;
            mshut_o    <= 1'b0;
            strobe_o   <= 1'b0;
        end else begin
            if (cfg_gate_en && evt.gate_end)
                skip_armed <= 1'b1;
            else if (evt.norm_end)
                skip_armed <= 1'b0;
            subck_o  <= subck_c;
            vsg_o    <= cfg_gate_en && evt.gate_hit;
            mshut_o  <= mshut_c;
            strobe_o <= strobe_c;
        end
    end

    AST_SHUT_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !cfg_shut_en |=> !subck_o); // R9
    AST_MSHUT_MASKS: assert property (@(posedge clk) disable iff (rst)
        (cfg_mshut_mask && mshut_c) |=> !subck_o); // R8
    AST_GATE_DISABLED: assert property (@(posedge clk) disable iff (rst)
        !cfg_gate_en |=> !vsg_o); // R10
    AST_STROBE_HELD: assert property (@(posedge clk) disable iff (rst)
        !cfg_strobe_en |=> !strobe_o); // R12
    AST_FLAG_ARMS: assert property (@(posedge clk) disable iff (rst)
        (cfg_gate_en && evt.gate_end) |=> skip_armed); // R5
    AST_MSHUT_OPEN: assert property (@(posedge clk) disable iff (rst)
        (cfg_mshut_pat == 2'd0) |=> !mshut_o); // R11
    AST_MSHUT_SHUT: assert property (@(posedge clk) disable iff (rst)
        (cfg_mshut_pat == 2'd3) |=> mshut_o); // R11

endmodule

// File: tb/sim_eshutter_gen.sv
module sim_eshutter_gen;
    localparam int CLK_PERIOD = 10;
    localparam int LINE_LEN   = 48;
    localparam int FIELD_LNS  = 10;
    localparam int FIELDS     = 48;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] h_pos;
    logic [10:0] v_line, vsg_line, cfg_shut_count;
    logic        cfg_pat_sel, cfg_skip_first, cfg_hp_multi;
    logic [2:0]  cfg_hp_num;
    logic        cfg_mshut_mask, cfg_shut_en, cfg_gate_en, cfg_strobe_en;
    logic [1:0]  cfg_mshut_pat;
    logic        subck_o, vsg_o, mshut_o, strobe_o;

    int checks = 0;
    int fails  = 0;
    bit m_flag = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    eshutter_gen u0 (
        .clk(clk), .rst(rst), .h_pos(h_pos), .v_line(v_line), .vsg_line(vsg_line),
        .cfg_shut_count(cfg_shut_count), .cfg_pat_sel(cfg_pat_sel),
        .cfg_skip_first(cfg_skip_first), .cfg_hp_multi(cfg_hp_multi),
        .cfg_hp_num(cfg_hp_num), .cfg_mshut_mask(cfg_mshut_mask),
        .cfg_shut_en(cfg_shut_en), .cfg_gate_en(cfg_gate_en),
        .cfg_mshut_pat(cfg_mshut_pat), .cfg_strobe_en(cfg_strobe_en),
        .subck_o(subck_o), .vsg_o(vsg_o), .mshut_o(mshut_o), .strobe_o(strobe_o)
    );

    function automatic bit in_w(int h, int p, int w);
        return (h >= p) && (h < p + w);
    endfunction

    task automatic chk(string tag, logic act, logic exp, int f, int v, int h);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s field %0d line %0d pix %0d: actual %b expected %b",
                     tag, f, v, h, act, exp);
        end
    endtask

    task automatic set_cfg(int f);
        int cnt_sel;
        int vsg_sel;
        cnt_sel = f % 5;
        vsg_sel = (f / 5) % 4;
        case (cnt_sel)
            0: cfg_shut_count = 11'd0;
            1: cfg_shut_count = 11'd1;
            2: cfg_shut_count = 11'd3;
            3: cfg_shut_count = 11'd5;
            default: cfg_shut_count = 11'h7FF;
        endcase
        case (vsg_sel)
            0: vsg_line = 11'd9;
            1: vsg_line = 11'd4;
            2: vsg_line = 11'd0;
            default: vsg_line = 11'd6;
        endcase
        cfg_pat_sel    = f[0] ^ f[3];
        cfg_skip_first = ((f / 2) % 2) == 1;
        cfg_hp_multi   = ((f / 3) % 2) == 1;
        cfg_hp_num     = 3'(f % 8);
        cfg_mshut_pat  = 2'((f / 4) % 4);
        cfg_mshut_mask = ((f / 7) % 2) == 1;
        cfg_shut_en    = (f % 11) != 10;
        cfg_gate_en    = (f % 9) != 8;
        cfg_strobe_en  = ((f / 6) % 2) == 1;
    endtask

    task automatic run_cycle(int f, int v, int h);
        int  cnt, vsg, stop, num;
        bit  norm, nend, hp, ms, e_sub, e_gate, e_str, gend;
        string tag;
        @(negedge clk);
        h_pos  = 12'(h);
        v_line = 11'(v);
        cnt  = int'(cfg_shut_count);
        vsg  = int'(vsg_line);
        num  = int'(cfg_hp_num);
        stop = (cnt < vsg) ? cnt : vsg;
        norm = (v < stop) && (cfg_pat_sel ? in_w(h, 10, 6) : in_w(h, 2, 3));
        nend = (v < stop) && (h == (cfg_pat_sel ? 15 : 4));
        hp = 1'b0;
        if (v == vsg) begin
            if (cfg_hp_multi) begin
                for (int k = 0; k < num; k++) if (h == 20 + 2 * k) hp = 1'b1;
            end else begin
                hp = (h == 20 + 2 * num);
            end
        end
        case (cfg_mshut_pat)
            2'd0: ms = 1'b0;
            2'd1: ms = v >= vsg;
            2'd2: ms = v < vsg;
            default: ms = 1'b1;
        endcase
        e_sub  = cfg_shut_en && !(cfg_mshut_mask && ms) &&
                 ((norm && !(m_flag && cfg_skip_first)) || hp);
        e_gate = cfg_gate_en && (v == vsg) && in_w(h, 40, 4);
        gend   = cfg_gate_en && (v == vsg) && (h == 43);
        e_str  = cfg_strobe_en && (v >= stop) && (v < vsg);
        if (!cfg_shut_en)                      tag = "R9 shut enable";
        else if (cfg_mshut_mask && ms)         tag = "R8 shutter mask";
        else if (v == vsg && cfg_hp_multi)     tag = "R7 multi fine pulses";
        else if (v == vsg)                     tag = "R6 single fine pulse";
        else if (m_flag && cfg_skip_first)     tag = "R5 first-pulse skip";
        else if (cnt == 11'h7FF)               tag = "R4 count bound";
        else if (cfg_pat_sel)                  tag = "R3 pattern B";
        else                                   tag = "R2 pattern A";
        @(posedge clk);
        #1;
        chk(tag, subck_o, e_sub, f, v, h);
        chk("R10 sensor gate", vsg_o, e_gate, f, v, h);
        chk("R11 shutter pattern", mshut_o, ms, f, v, h);
        chk("R12 strobe", strobe_o, e_str, f, v, h);
        if (gend) m_flag = 1'b1;
        else if (nend) m_flag = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1;
        h_pos = '0;
        v_line = '0;
        set_cfg(0);
        cfg_mshut_pat = 2'd3;
        cfg_strobe_en = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        // R1: reset holds every output low even with active config
        chk("R1 reset subck", subck_o, 1'b0, -1, 0, 0);
        chk("R1 reset gate", vsg_o, 1'b0, -1, 0, 0);
        chk("R1 reset shutter", mshut_o, 1'b0, -1, 0, 0);
        chk("R1 reset strobe", strobe_o, 1'b0, -1, 0, 0);
        @(negedge clk);
        rst = 1'b0;
        for (int f = 0; f < FIELDS; f++) begin
            set_cfg(f);
            for (int v = 0; v < FIELD_LNS; v++)
                for (int h = 0; h < LINE_LEN; h++)
                    run_cycle(f, v, h);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule